// File: doc/BRIEF.md
# Power-Up Trim Boot Sequencer

This block orders the first microseconds of a mixed-signal chip after the power-on reset lets go. It fetches the analog calibration words from one fixed bank of the nonvolatile store, one address per read request, and drops each word into its own trim register. After a minimum load time it waits out a settling interval and then raises a trim-valid flag. The embedded processor is held in reset until a fixed time from reset release has passed and the trims are valid.

Every phase is timed in system clock cycles (40 MHz in the target, so the defaults are 320 load cycles, 480 settle cycles and 1200 cycles of processor hold). The memory may stall a read by holding its ready input low. The load then stretches past its minimum, and every later milestone moves with it. If the power-on reset drops again at any time, the sequence starts over from nothing.

Top module: `pwrup_boot_seq`

## Requirements
- R1: While `por_n` is low, `trim_valid`, `cpu_rst_n` and `mem_rd` are 0 and every trim slot holds zero.
- R2: Each read puts the bank number `BANK_ID` in the upper `BANK_W` address bits and the word index in the lower bits. The index starts at 0 and advances only on an edge where `mem_rd` and `mem_ready` are both 1. On that edge `mem_rdata` is stored in slot index, which is bits [index*TRIM_W +: TRIM_W] of `trim_bus`.
- R3: `mem_rd` is 1 only during the load phase, and only while fewer than `NUM_TRIM` words have been taken.
- R4: Counting edges from the first edge that samples `por_n` high as edge 1, the load phase ends on the later of edge `LOAD_CYC` and the edge after the last word is captured. It never ends earlier, even when all words arrive early.
- R5: `trim_valid` rises exactly `WAIT_CYC` edges after the load phase ends. With no stalls this is edge `LOAD_CYC+WAIT_CYC`.
- R6: `cpu_rst_n` rises on the later of edge `HOLD_CYC` and the edge on which `trim_valid` rises. It is never 1 while `trim_valid` is 0.
- R7: An edge that samples `por_n` low clears `trim_valid`, `cpu_rst_n` and all trim slots. The next release restarts the sequence at index 0.
- R8: Once set, `trim_valid` and `cpu_rst_n` are registered levels that stay 1 until `por_n` falls, and the trim slots do not change while `trim_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| mem_rd | output | 1 | Read request to the nonvolatile store |
| mem_addr | output | ADDR_W | Read address: bank in upper bits, word index in lower bits |
| mem_rdata | input | TRIM_W | Read data, taken when `mem_ready` is high |
| mem_ready | input | 1 | Store has data for the current request |
| trim_bus | output | NUM_TRIM*TRIM_W | All trim slots, slot 0 in the least significant bits |
| trim_valid | output | 1 | Trim slots hold settled, loaded values |
| cpu_rst_n | output | 1 | Processor reset, active low |

## Verification
The bench builds the block with `LOAD_CYC=16`, `WAIT_CYC=10`, `HOLD_CYC=40` and four 16-bit trim words. These values keep every phase boundary within a few dozen cycles. With them a long ready stall can push trim-valid past the processor hold time, so the release waits on the trims. A shorter stall ends the load between its minimum and the hold time. The bench also drops the power-on reset during the load, during the settle phase and after the processor runs, and restarts each time.

// File: rtl/boot_seq_pkg.sv
// Package: types shared by the power-up boot sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package boot_seq_pkg;

    // Sequencer phases, in the order they are walked after reset release.
    typedef enum logic [2:0] {
        BS_RESET  = 3'd0,
        BS_LOAD   = 3'd1,
        BS_SETTLE = 3'd2,
        BS_HOLD   = 3'd3,
        BS_RUN    = 3'd4
    } boot_state_e;

endpackage

// File: rtl/boot_cycle_ctr.sv
// Module: saturating cycle counter with synchronous clear.
// Counts one per clock up to MAX and stays there. Assumes rst_n is
// synchronous and active low, and clr takes priority over counting.
module boot_cycle_ctr #(
    parameter int MAX = 16,
    parameter int CW  = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LIMIT = CW'(MAX);

    // Count up, clear on reset or request, saturate at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt < LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/boot_trim_loader.sv
// Module: trim word fetcher.
// While active, it requests words from one memory bank one address at a
// time. Each word acknowledged by mem_ready goes into the next trim slot.
// Assumes the memory returns data in the cycle it raises ready, and rst_n
// is synchronous, active low.
module boot_trim_loader #(
    parameter int NUM_TRIM = 8,
    parameter int TRIM_W   = 16,
    parameter int BANK_W   = 4,
    parameter int BANK_ID  = 6,
    parameter int ADDR_W   = BANK_W + $clog2(NUM_TRIM)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       mem_ready,
    input  logic [TRIM_W-1:0]          mem_rdata,
    output logic                       mem_rd,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [NUM_TRIM*TRIM_W-1:0] trim_bus,
    output logic                       done
);

    localparam int IDX_W = ADDR_W - BANK_W;
    localparam int CW    = $clog2(NUM_TRIM + 1);
    localparam logic [CW-1:0]     LAST_CNT = CW'(NUM_TRIM);
    localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_ID);

    logic [CW-1:0] idx_q;
    logic          take;

    // Request and address come from the registered index and phase.
    always_comb begin
        done     = (idx_q == LAST_CNT);
        mem_rd   = active && !done;
        mem_addr = {BANK_SEL, idx_q[IDX_W-1:0]};
        take     = mem_rd && mem_ready;
    end

    // Word index: cleared by reset, advanced on every accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // One capture register per trim slot.
    for (genvar i = 0; i < NUM_TRIM; i++) begin : g_slot
        logic [TRIM_W-1:0] word_q;

        // Capture the read data when this slot's index is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (take && (idx_q == CW'(i))) begin
                word_q <= mem_rdata;
            end
        end

        assign trim_bus[i*TRIM_W +: TRIM_W] = word_q;
    end

endmodule

// File: rtl/boot_ctrl.sv
// Module: boot phase controller.
// Walks reset, load, settle, hold and run. The phase counter times load
// and settle; the elapsed counter times the processor hold. The trim-valid
// and processor reset outputs are registers decoded from the next state.
// Assumes the phase counter clears on every edge where the state changes,
// and the elapsed counter counts edges since reset release.
module boot_ctrl
    import boot_seq_pkg::*;
#(
    parameter int LOAD_CYC = 320,
    parameter int WAIT_CYC = 480,
    parameter int HOLD_CYC = 1200,
    parameter int PH_W     = 9,
    parameter int EL_W     = 11
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [PH_W-1:0] ph,
    input  logic [EL_W-1:0] el,
    input  logic            load_done,
    output boot_state_e     state,
    output logic            phase_clr,
    output logic            trim_valid,
    output logic            cpu_rst_n
);

    // Load spans edges 1..LOAD_CYC: the phase counter reads 0 after edge 1.
    localparam logic [PH_W-1:0] LOAD_LAST   = PH_W'(LOAD_CYC - 2);
    localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(WAIT_CYC - 1);
    localparam logic [EL_W-1:0] HOLD_LAST   = EL_W'(HOLD_CYC - 1);

    boot_state_e nxt;

    // Next-phase decision from registered state and counters.
    always_comb begin
        nxt = state;
        case (state)
            BS_RESET:  nxt = BS_LOAD;
            BS_LOAD:   if (load_done && (ph >= LOAD_LAST)) nxt = BS_SETTLE;
            BS_SETTLE: if (ph >= SETTLE_LAST) begin
                           nxt = (el >= HOLD_LAST) ? BS_RUN : BS_HOLD;
                       end
            BS_HOLD:   if (el >= HOLD_LAST) nxt = BS_RUN;
            BS_RUN:    nxt = BS_RUN;
            default:   nxt = BS_RESET;
        endcase
        phase_clr = (nxt != state);
    end

    // State and glitch-free outputs; reset release restarts everything.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state      <= BS_RESET;
            trim_valid <= 1'b0;
            cpu_rst_n  <= 1'b0;
        end else begin
            state      <= nxt;
            trim_valid <= (nxt == BS_HOLD) || (nxt == BS_RUN);
            cpu_rst_n  <= (nxt == BS_RUN);
        end
    end

endmodule

// File: rtl/pwrup_boot_seq.sv
// Module: power-up trim boot sequencer (top).
// After the power-on reset releases, it loads NUM_TRIM words from bank
// BANK_ID into the trim slots. It then settles, flags the trims valid and
// releases the processor no earlier than HOLD_CYC edges after release.
// Assumes por_n is synchronous to clk and LOAD_CYC >= 2, WAIT_CYC >= 1,
// NUM_TRIM >= 2.
module pwrup_boot_seq
    import boot_seq_pkg::*;
#(
    parameter int LOAD_CYC = 320,
    parameter int WAIT_CYC = 480,
    parameter int HOLD_CYC = 1200,
    parameter int NUM_TRIM = 8,
    parameter int TRIM_W   = 16,
    parameter int BANK_W   = 4,
    parameter int BANK_ID  = 6,
    parameter int ADDR_W   = BANK_W + $clog2(NUM_TRIM)
) (
    input  logic                       clk,
    input  logic                       por_n,
    output logic                       mem_rd,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic [TRIM_W-1:0]          mem_rdata,
    input  logic                       mem_ready,
    output logic [NUM_TRIM*TRIM_W-1:0] trim_bus,
    output logic                       trim_valid,
    output logic                       cpu_rst_n
);

    localparam int PH_MAX = (LOAD_CYC > WAIT_CYC) ? LOAD_CYC : WAIT_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int EL_W   = $clog2(HOLD_CYC + 1);

    boot_state_e     state;
    logic            phase_clr;
    logic            load_done;
    logic [PH_W-1:0] ph;
    logic [EL_W-1:0] el;

    // Phase timer, restarted on every phase change.
    boot_cycle_ctr #(.MAX(PH_MAX), .CW(PH_W)) u_phase_ctr (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (phase_clr),
        .cnt   (ph)
    );

    // Elapsed timer since reset release, for the processor hold.
    boot_cycle_ctr #(.MAX(HOLD_CYC), .CW(EL_W)) u_elapsed_ctr (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (1'b0),
        .cnt   (el)
    );

    boot_trim_loader #(
        .NUM_TRIM (NUM_TRIM),
        .TRIM_W   (TRIM_W),
        .BANK_W   (BANK_W),
        .BANK_ID  (BANK_ID),
        .ADDR_W   (ADDR_W)
    ) u_loader (
        .clk       (clk),
        .rst_n     (por_n),
        .active    (state == BS_LOAD),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .trim_bus  (trim_bus),
        .done      (load_done)
    );

    boot_ctrl #(
        .LOAD_CYC (LOAD_CYC),
        .WAIT_CYC (WAIT_CYC),
        .HOLD_CYC (HOLD_CYC),
        .PH_W     (PH_W),
        .EL_W     (EL_W)
    ) u_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .ph         (ph),
        .el         (el),
        .load_done  (load_done),
        .state      (state),
        .phase_clr  (phase_clr),
        .trim_valid (trim_valid),
        .cpu_rst_n  (cpu_rst_n)
    );

endmodule

// File: rtl/boot_seq_checker.sv
// Module: protocol and ordering checks for pwrup_boot_seq, bound to it.
// Observes top-level ports only.
module boot_seq_checker #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              por_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              trim_valid,
    input logic              cpu_rst_n
);

    logic seen_edge;
    logic por_prev;

    // Remember the previous reset sample for the restart check.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        por_prev  <= por_n;
    end

    // R7: an edge that sampled reset low leaves both flags cleared.
    always_ff @(posedge clk) begin
        if (seen_edge && !por_prev) begin
            a_r7_reset_clears: assert (!trim_valid && !cpu_rst_n)
                else $error("a_r7_reset_clears");
        end
    end

    // R6: processor never runs on unsettled trims.
    a_r6_cpu_after_valid: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst_n |-> trim_valid);

    // R3: no reads once the trims are declared valid.
    a_r3_quiet_when_valid: assert property (@(posedge clk) disable iff (!por_n)
        trim_valid |-> !mem_rd);

    // R8: trim-valid holds until reset.
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!por_n)
        trim_valid |=> trim_valid);

    // R8: processor release holds until reset.
    a_r8_cpu_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst_n |=> cpu_rst_n);

    // R2: a stalled read keeps its address.
    a_r2_stall_holds_addr: assert property (@(posedge clk) disable iff (!por_n)
        (mem_rd && !mem_ready) |=> (!mem_rd || $stable(mem_addr)));

    // R2: an accepted read moves to the next word.
    a_r2_accept_advances: assert property (@(posedge clk) disable iff (!por_n)
        (mem_rd && mem_ready) |=>
            (!mem_rd || (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

endmodule

bind pwrup_boot_seq boot_seq_checker #(.ADDR_W(ADDR_W)) u_boot_chk (
    .clk        (clk),
    .por_n      (por_n),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .trim_valid (trim_valid),
    .cpu_rst_n  (cpu_rst_n)
);

// File: tb/tb_pwrup_boot_seq.sv
// Bench: behavioural reference model stepped once per clock and compared
// with every output. Inputs change on the falling edge.
module tb_pwrup_boot_seq;

    localparam int L  = 16;
    localparam int W  = 10;
    localparam int H  = 40;
    localparam int N  = 4;
    localparam int TW = 16;
    localparam int BW = 4;
    localparam int BK = 6;
    localparam int IW = 2;
    localparam int AW = BW + IW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            por_n;
    logic            mem_rd;
    logic [AW-1:0]   mem_addr;
    logic [TW-1:0]   mem_rdata;
    logic            mem_ready;
    logic [N*TW-1:0] trim_bus;
    logic            trim_valid;
    logic            cpu_rst_n;

    // Memory stub: contents are a fixed function of the address.
    function automatic logic [TW-1:0] rom(input int a);
        return TW'((a * 937) ^ 16'h5C3A);
    endfunction

    assign mem_rdata = rom(int'(mem_addr));

    pwrup_boot_seq #(
        .LOAD_CYC (L), .WAIT_CYC (W), .HOLD_CYC (H),
        .NUM_TRIM (N), .TRIM_W (TW), .BANK_W (BW), .BANK_ID (BK)
    ) dut (
        .clk (clk), .por_n (por_n), .mem_rd (mem_rd), .mem_addr (mem_addr),
        .mem_rdata (mem_rdata), .mem_ready (mem_ready), .trim_bus (trim_bus),
        .trim_valid (trim_valid), .cpu_rst_n (cpu_rst_n)
    );

    // Reference model state, as seen after the latest rising edge.
    int          m_e, m_cnt, m_end;
    bit          m_valid, m_cpu, m_valid_old, m_cpu_old, had_run;
    logic [TW-1:0] m_trim [N];
    int          n_chk, n_fail, cyc, ready_mode, stall_until;
    bit          finished;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance the model by one rising edge using the inputs held there.
    task automatic model_step();
        bit in_load, done_pre;
        int e_new;
        in_load     = (m_e >= 1) && (m_end == 0);
        done_pre    = (m_cnt == N);
        m_valid_old = m_valid;
        m_cpu_old   = m_cpu;
        if (!por_n) begin
            if (m_e != 0) had_run = 1'b1;
            m_e = 0; m_cnt = 0; m_end = 0; m_valid = 0; m_cpu = 0;
            for (int i = 0; i < N; i++) m_trim[i] = '0;
        end else begin
            e_new = m_e + 1;
            if (in_load && !done_pre && mem_ready) begin
                m_trim[m_cnt] = rom(BK * (1 << IW) + m_cnt);
                m_cnt++;
            end
            if (in_load && done_pre && e_new >= L) m_end = e_new;
            if (m_end != 0 && e_new >= m_end + W) m_valid = 1'b1;
            if (m_valid && e_new >= H) m_cpu = 1'b1;
            m_e = e_new;
        end
    endtask

    // Compare every output against the model.
    task automatic compare();
        string rt, tv, tc;
        bit exp_rd;
        logic [N*TW-1:0] exp_bus;
        rt = had_run ? "R7" : "R1";
        exp_rd = (m_e >= 1) && (m_end == 0) && (m_cnt < N);
        for (int i = 0; i < N; i++) exp_bus[i*TW +: TW] = m_trim[i];
        if (m_e == 0) tv = rt;
        else if (m_valid && m_valid_old) tv = "R8";
        else if (m_end == 0 && m_cnt == N) tv = "R4";
        else tv = "R5";
        if (m_e == 0) tc = rt;
        else if (m_cpu && m_cpu_old) tc = "R8";
        else tc = "R6";
        check(trim_valid == m_valid, tv, "trim_valid", 64'(trim_valid), 64'(m_valid));
        check(cpu_rst_n == m_cpu, tc, "cpu_rst_n", 64'(cpu_rst_n), 64'(m_cpu));
        check(mem_rd == exp_rd, (m_e == 0) ? rt : "R3", "mem_rd",
              64'(mem_rd), 64'(exp_rd));
        if (exp_rd)
            check(int'(mem_addr) == BK * (1 << IW) + m_cnt, "R2", "mem_addr",
                  64'(mem_addr), 64'(BK * (1 << IW) + m_cnt));
        check(trim_bus == exp_bus, (m_e == 0) ? rt : (m_valid ? "R8" : "R2"),
              "trim_bus", 64'(trim_bus), 64'(exp_bus));
    endtask

    // One clock: step model, compare, then drive the next inputs.
    task automatic tick();
        @(negedge clk);
        model_step();
        compare();
        cyc++;
        case (ready_mode)
            0: mem_ready = 1'b1;
            1: mem_ready = (cyc % 3 == 0);
            default: mem_ready = (m_e >= stall_until);
        endcase
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic run_until_e(input int e);
        for (int i = 0; i < 400 && m_e < e; i++) tick();
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        por_n = 1'b0; mem_ready = 1'b0; ready_mode = 0; stall_until = 0;
        n_chk = 0; n_fail = 0; cyc = 0; finished = 0; had_run = 0;
        m_e = 0; m_cnt = 0; m_end = 0; m_valid = 0; m_cpu = 0;
        for (int i = 0; i < N; i++) m_trim[i] = '0;

        // R1: held in reset.
        run(4);

        // Nominal boot, memory always ready (R4, R5, R6).
        por_n = 1'b1;
        run_until_e(L + W - 1);
        check(trim_valid == 1'b0, "R5", "trim_valid one edge early", 64'(trim_valid), 64'd0);
        tick();
        check(trim_valid == 1'b1, "R5", "trim_valid at L+W", 64'(trim_valid), 64'd1);
        run_until_e(H);
        check(cpu_rst_n == 1'b1, "R6", "cpu_rst_n at hold time", 64'(cpu_rst_n), 64'd1);
        run(5);

        // R7: reset during RUN, then a sparse-ready boot cut off mid-settle.
        por_n = 1'b0; run(2);
        check(trim_valid == 1'b0 && trim_bus == '0, "R7", "cleared after reset",
              64'(trim_bus), 64'd0);
        ready_mode = 1; por_n = 1'b1;
        run_until_e(20);
        por_n = 1'b0; run(2);
        por_n = 1'b1; run(50);

        // Long stall: trims settle after hold time, release waits (R6).
        por_n = 1'b0; ready_mode = 2; stall_until = 30; run(1);
        por_n = 1'b1;
        run_until_e(44);
        check(cpu_rst_n == 1'b0, "R6", "cpu held for late trims", 64'(cpu_rst_n), 64'd0);
        tick();
        check(trim_valid && cpu_rst_n, "R6", "release with trims", 64'(cpu_rst_n), 64'd1);
        run(4);

        // Medium stall: load ends between minimum and hold time (R4).
        por_n = 1'b0; stall_until = 20; run(1);
        por_n = 1'b1; run(50);

        // One-cycle reset glitch during load, then nominal (R7).
        por_n = 1'b0; ready_mode = 0; run(1);
        por_n = 1'b1; run_until_e(3);
        por_n = 1'b0; run(1);
        por_n = 1'b1; run(50);

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule